// File: doc/BRIEF.md
# Folded Shift Register Bit-Error Checker

The block is a ten-cell serial shift register folded into two branches of five cells each. A test bit enters the first cell of the forward branch. It walks through that branch and turns into the return branch at the far stage. It then walks back and leaves at a serial output. Four comparators sit between the stages. Each one exclusive-ORs a forward-branch cell with the return-branch cell of the following stage. Because of the fold, every comparator sees two copies of one stream a fixed, even number of clocks apart. The comparison result is registered as a per-stage error flag on the next clock edge.

The test stream comes from a pattern selector. It offers a constant zero stream, a constant one stream, a free-running 15-bit maximal-length pseudo-random sequence, and a bit-per-clock external input for arbitrary low-speed sequences. With a constant stream the flags stay low once the register is full. Any flag raised after the fill period therefore marks a corrupted bit. A 16-bit saturating counter sums the raised flags of all four stages. It counts only after a fill period of ten edges, which restarts on reset and whenever the selection changes.

Top module: `fsr_ber_checker`

## Requirements
- R1: An active-high synchronous reset clears all ten cells, the four flags, the fill progress and the error count, so `ser_out`, `stage_err` and `err_count` read zero after a reset edge.
- R2: A bit captured into the register at edge n appears on `ser_out` right after edge n+9, which is ten edges counting the capturing one. Cells not yet written since reset read as zero.
- R3: `pat_sel` chooses the bit captured at each edge: 2'b00 a zero, 2'b01 a one, 2'b10 bit 14 of a 15-bit LFSR (shift left, new bit 0 = bit14 XOR bit13, i.e. x^15+x^14+1; reset to the nonzero seed 15'h1ACE; it advances every edge), and 2'b11 the level of `ser_in`.
- R4: After edge n+1, `stage_err[i]` (i = 0..3) equals b(n-i) XOR b(n-8+i), where b(k) is the bit captured at edge k. The taps are therefore 8, 6, 4 and 2 clocks apart.
- R5: The counter accumulates only at edges where at least ten edges have passed since reset or since the last selection change. An edge at which `pat_sel` differs from its value at the previous edge counts as the first fill edge.
- R6: At each enabled edge, `err_count` grows by the number of set bits in `stage_err` as presented before that edge. It stays unchanged when no flag is set.
- R7: `err_count` saturates at 16'hFFFF and does not wrap.
- R8: `cnt_clr` zeroes `err_count` at the next edge and overrides accumulation.
- R9: With a constant stream (2'b00 or 2'b01) held past the fill period, every `stage_err` bit stays low and `err_count` stays constant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pat_sel | input | 2 | Test stream selection (zeros, ones, pseudo-random, external) |
| ser_in | input | 1 | External serial bit, used when `pat_sel` is 2'b11 |
| cnt_clr | input | 1 | Synchronous clear of the error count |
| ser_out | output | 1 | Last cell of the return branch |
| stage_err | output | 4 | Registered comparator results, one per stage boundary |
| err_count | output | 16 | Saturating count of flagged mismatches |

## Verification
Constant one and zero streams show that the register fills without false flags. They also show that the counter holds during the ten-edge fill and stays flat afterwards. An externally driven irregular bit sequence separates the four tap distances and the ten-edge serial delay, because a wrong tap or an off-by-one shift changes the flag and output values. The pseudo-random stream checks the LFSR sequence. It also drives the count to saturation, where clearing and reset in the middle of a run are exercised.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    // Source of the bit captured into the first forward cell.
    typedef enum logic [1:0] {
        PAT_ZERO = 2'b00,
        PAT_ONE  = 2'b01,
        PAT_PRBS = 2'b10,
        PAT_EXT  = 2'b11
    } pat_sel_e;

    localparam int SEL_W = 2;

endpackage

// File: rtl/fsr_pattern_gen.sv
module fsr_pattern_gen
    import fsr_pkg::*;
#(
    parameter int              LFSR_W = 15,
    parameter logic [LFSR_W-1:0] SEED = 15'h1ACE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] pat_sel,
    input  logic             ser_in,
    output logic             pat_bit
);

    // A zero seed would lock the LFSR; fall back to one.
    localparam logic [LFSR_W-1:0] SEED_EFF =
        (SEED == '0) ? LFSR_W'(1) : SEED;
    localparam int TAP_HI = LFSR_W - 1;
    localparam int TAP_LO = LFSR_W - 2;

    typedef struct packed {
        logic [LFSR_W-1:0] lfsr;
    } gen_state_t;

    gen_state_t st_d, st_q;
    logic       feedback;

    always_comb begin
        st_d     = st_q;
        feedback = st_q.lfsr[TAP_HI] ^ st_q.lfsr[TAP_LO];
        st_d.lfsr = {st_q.lfsr[LFSR_W-2:0], feedback};

        case (pat_sel_e'(pat_sel))
            PAT_ZERO: pat_bit = 1'b0;
            PAT_ONE:  pat_bit = 1'b1;
            PAT_PRBS: pat_bit = st_q.lfsr[TAP_HI];
            default:  pat_bit = ser_in;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.lfsr <= SEED_EFF;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/fsr_fold_chain.sv
module fsr_fold_chain #(
    parameter int STAGES = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              din,
    output logic              ser_out,
    output logic [STAGES-2:0] flags
);

    localparam int NCHK = STAGES - 1;

    // fwd[k]: forward-branch cell of stage k (data moves up in k).
    // ret[k]: return-branch cell of stage k (data moves down in k).
    typedef struct packed {
        logic [STAGES-1:0] fwd;
        logic [STAGES-1:0] ret;
        logic [NCHK-1:0]   flag;
    } chain_state_t;

    chain_state_t    st_d, st_q;
    logic [NCHK-1:0] cmp_w;

    // One comparator per stage boundary: forward cell of stage i
    // against the return cell of stage i+1.
    for (genvar i = 0; i < NCHK; i++) begin : g_cmp
        assign cmp_w[i] = st_q.fwd[i] ^ st_q.ret[i+1];
    end

    always_comb begin
        st_d      = st_q;
        st_d.fwd  = {st_q.fwd[STAGES-2:0], din};
        st_d.ret  = {st_q.fwd[STAGES-1], st_q.ret[STAGES-1:1]};
        st_d.flag = cmp_w;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ser_out = st_q.ret[0];
    assign flags   = st_q.flag;

endmodule

// File: rtl/fsr_err_counter.sv
module fsr_err_counter
    import fsr_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int NFLAG    = 4,
    parameter int FILL_LEN = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] pat_sel,
    input  logic             cnt_clr,
    input  logic [NFLAG-1:0] flags,
    output logic [CNT_W-1:0] err_count
);

    localparam int              FILL_W   = $clog2(FILL_LEN + 1);
    localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(FILL_LEN);
    localparam int              POP_W    = $clog2(NFLAG + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [FILL_W-1:0] fill;
        logic [CNT_W-1:0]  cnt;
    } cnt_state_t;

    cnt_state_t       st_d, st_q;
    logic [POP_W-1:0] pop;
    logic [CNT_W:0]   sum;
    logic             armed;

    always_comb begin
        st_d     = st_q;
        st_d.sel = pat_sel;

        // Fill progress restarts when the stream source changes.
        if (pat_sel != st_q.sel) begin
            st_d.fill = FILL_W'(1);
        end else if (st_q.fill != FILL_MAX) begin
            st_d.fill = st_q.fill + FILL_W'(1);
        end
        armed = (st_q.fill == FILL_MAX);

        pop = '0;
        for (int k = 0; k < NFLAG; k++) begin
            pop = pop + POP_W'(flags[k]);
        end
        sum = {1'b0, st_q.cnt} + (CNT_W+1)'(pop);

        if (cnt_clr) begin
            st_d.cnt = '0;
        end else if (armed) begin
            st_d.cnt = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_count = st_q.cnt;

endmodule

// File: rtl/fsr_ber_checker.sv
module fsr_ber_checker
    import fsr_pkg::*;
#(
    parameter int                STAGES = 5,
    parameter int                CNT_W  = 16,
    parameter int                LFSR_W = 15,
    parameter logic [LFSR_W-1:0] SEED   = 15'h1ACE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        pat_sel,
    input  logic              ser_in,
    input  logic              cnt_clr,
    output logic              ser_out,
    output logic [STAGES-2:0] stage_err,
    output logic [CNT_W-1:0]  err_count
);

    localparam int NCHK     = STAGES - 1;
    localparam int FILL_LEN = 2 * STAGES;

    logic pat_bit_w;

    fsr_pattern_gen #(
        .LFSR_W (LFSR_W),
        .SEED   (SEED)
    ) u_gen (
        .clk     (clk),
        .rst     (rst),
        .pat_sel (pat_sel),
        .ser_in  (ser_in),
        .pat_bit (pat_bit_w)
    );

    fsr_fold_chain #(
        .STAGES (STAGES)
    ) u_chain (
        .clk     (clk),
        .rst     (rst),
        .din     (pat_bit_w),
        .ser_out (ser_out),
        .flags   (stage_err)
    );

    fsr_err_counter #(
        .CNT_W    (CNT_W),
        .NFLAG    (NCHK),
        .FILL_LEN (FILL_LEN)
    ) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .pat_sel   (pat_sel),
        .cnt_clr   (cnt_clr),
        .flags     (stage_err),
        .err_count (err_count)
    );

endmodule

// File: rtl/fsr_ber_checker_sva.sv
module fsr_ber_checker_sva #(
    parameter int STAGES = 5,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        pat_sel,
    input logic              cnt_clr,
    input logic              pat_bit,
    input logic              ser_out,
    input logic [STAGES-2:0] stage_err,
    input logic [CNT_W-1:0]  err_count
);

    localparam int FILL_LEN = 2 * STAGES;
    localparam int NCHK     = STAGES - 1;
    localparam int RUN_W    = $clog2(FILL_LEN + 1);

    logic [FILL_LEN-1:0] hist_q;
    logic [RUN_W-1:0]    run_q;
    logic [1:0]          sel_q;
    logic                rst_seen_q;

    // Independent record of every captured bit and of the fill window.
    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
        if (rst) begin
            hist_q <= '0;
            run_q  <= '0;
            sel_q  <= '0;
        end else begin
            hist_q <= {hist_q[FILL_LEN-2:0], pat_bit};
            sel_q  <= pat_sel;
            if (pat_sel != sel_q) begin
                run_q <= RUN_W'(1);
            end else if (run_q != RUN_W'(FILL_LEN)) begin
                run_q <= run_q + RUN_W'(1);
            end
        end
        if (rst_seen_q) begin
            p_reset_clear_r1: assert (ser_out == 1'b0 && stage_err == '0
                                      && err_count == '0);
        end
    end

    p_serial_delay_r2: assert property (@(posedge clk) disable iff (rst)
        ser_out == hist_q[FILL_LEN-1]);

    for (genvar i = 0; i < NCHK; i++) begin : g_tap
        p_tap_compare_r4: assert property (@(posedge clk) disable iff (rst)
            stage_err[i] == (hist_q[i+1] ^ hist_q[FILL_LEN-1-i]));
    end

    p_hold_in_fill_r5: assert property (@(posedge clk) disable iff (rst)
        (run_q != RUN_W'(FILL_LEN) && !cnt_clr) |=> $stable(err_count));

    p_idle_no_flags_r6: assert property (@(posedge clk) disable iff (rst)
        (!cnt_clr && stage_err == '0) |=> $stable(err_count));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        (&err_count && !cnt_clr) |=> &err_count);

    p_clear_wins_r8: assert property (@(posedge clk) disable iff (rst)
        cnt_clr |=> err_count == '0);

endmodule

bind fsr_ber_checker fsr_ber_checker_sva #(
    .STAGES (STAGES),
    .CNT_W  (CNT_W)
) u_sva (
    .clk       (clk),
    .rst       (rst),
    .pat_sel   (pat_sel),
    .cnt_clr   (cnt_clr),
    .pat_bit   (pat_bit_w),
    .ser_out   (ser_out),
    .stage_err (stage_err),
    .err_count (err_count)
);

// File: tb/fsr_ber_checker_tb.sv
`timescale 1ns/1ps
module fsr_ber_checker_tb;

    localparam logic [14:0] SEED_TB = 15'h1ACE;
    localparam int          NVEC    = 48;

    // Each vector: {pat_sel[1:0], ser_in, cnt_clr}.
    localparam logic [3:0] VEC [0:NVEC-1] = '{
        4'h4, 4'h4, 4'h4, 4'h4, 4'h4, 4'h4, 4'h4, 4'h4, 4'h4, 4'h4,
        4'h4, 4'h4, 4'h4, 4'h4,
        4'hE, 4'hC, 4'hE, 4'hE, 4'hC, 4'hC, 4'hE, 4'hC, 4'hE, 4'hE,
        4'hE, 4'hC, 4'hC, 4'hE, 4'hC, 4'hE,
        4'hD, 4'hF,
        4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0,
        4'hE, 4'hC, 4'hC, 4'hE, 4'hE, 4'hE
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  pat_sel = 2'b00;
    logic        ser_in = 1'b0;
    logic        cnt_clr = 1'b0;
    logic        ser_out;
    logic [3:0]  stage_err;
    logic [15:0] err_count;

    int checks = 0;
    int errors = 0;

    // Bench reference state, built from the requirements.
    logic [15:0] m_hist;
    logic [3:0]  m_flag;
    logic [15:0] m_cnt;
    logic [3:0]  m_fill;
    logic [1:0]  m_sel;
    logic [14:0] m_lfsr;

    always #5 clk = ~clk;

    fsr_ber_checker u_dut (
        .clk       (clk),
        .rst       (rst),
        .pat_sel   (pat_sel),
        .ser_in    (ser_in),
        .cnt_clr   (cnt_clr),
        .ser_out   (ser_out),
        .stage_err (stage_err),
        .err_count (err_count)
    );

    task automatic check(input string tag, input logic [15:0] got,
                         input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic model_edge();
        logic        b;
        logic [3:0]  nflag;
        logic [2:0]  pop;
        logic [16:0] sum;
        if (rst) begin
            m_hist = '0; m_flag = '0; m_cnt = '0; m_fill = '0;
            m_sel = '0; m_lfsr = SEED_TB;
        end else begin
            case (pat_sel)
                2'b00:   b = 1'b0;
                2'b01:   b = 1'b1;
                2'b10:   b = m_lfsr[14];
                default: b = ser_in;
            endcase
            for (int i = 0; i < 4; i++) nflag[i] = m_hist[i] ^ m_hist[8-i];
            pop = '0;
            for (int i = 0; i < 4; i++) pop = pop + {2'b00, m_flag[i]};
            sum = {1'b0, m_cnt} + {14'd0, pop};
            if (cnt_clr) m_cnt = '0;
            else if (m_fill == 4'd10) m_cnt = sum[16] ? 16'hFFFF : sum[15:0];
            if (pat_sel != m_sel) m_fill = 4'd1;
            else if (m_fill != 4'd10) m_fill = m_fill + 4'd1;
            m_sel  = pat_sel;
            m_flag = nflag;
            m_hist = {m_hist[14:0], b};
            m_lfsr = {m_lfsr[13:0], m_lfsr[14] ^ m_lfsr[13]};
        end
    endtask

    task automatic tick(input string tdout, input string tflag,
                        input string tcnt);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(tdout, {15'd0, ser_out}, {15'd0, m_hist[9]});
        check(tflag, {12'd0, stage_err}, {12'd0, m_flag});
        check(tcnt, err_count, m_cnt);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] held;
        // R1: reset state
        repeat (3) begin
            @(posedge clk);
            model_edge();
        end
        @(negedge clk);
        check("R1 ser_out", {15'd0, ser_out}, 16'd0);
        check("R1 stage_err", {12'd0, stage_err}, 16'd0);
        check("R1 err_count", err_count, 16'd0);
        rst = 1'b0;

        // Vector walk: ones fill, irregular external bits, clear, zeros.
        for (int v = 0; v < NVEC; v++) begin
            {pat_sel, ser_in, cnt_clr} = VEC[v];
            tick("R2 ser_out", "R4 stage_err", "R5 R6 err_count");
            cnt_clr = 1'b0;
        end

        // R3 / R9: constant ones held well past the fill period.
        pat_sel = 2'b01;
        repeat (12) tick("R3 ser_out", "R4 stage_err", "R5 err_count");
        held = err_count;
        for (int k = 0; k < 20; k++) begin
            tick("R3 ser_out", "R9 stage_err", "R9 err_count");
            check("R9 flags low", {12'd0, stage_err}, 16'd0);
            check("R9 count flat", err_count, held);
            check("R3 ones out", {15'd0, ser_out}, 16'd1);
        end

        // R3 zeros
        pat_sel = 2'b00;
        repeat (11) tick("R3 ser_out", "R4 stage_err", "R5 err_count");
        check("R3 zeros out", {15'd0, ser_out}, 16'd0);
        check("R9 zeros flags", {12'd0, stage_err}, 16'd0);

        // R3: pseudo-random stream, then R7 saturation.
        pat_sel = 2'b10;
        repeat (40) tick("R3 ser_out", "R4 stage_err", "R6 err_count");
        for (int k = 0; k < 60000 && m_cnt != 16'hFFFF; k++) begin
            tick("R3 ser_out", "R4 stage_err", "R7 err_count");
        end
        repeat (8) tick("R3 ser_out", "R4 stage_err", "R7 err_count");
        check("R7 saturated", err_count, 16'hFFFF);

        // R8: clear while saturated and flags active.
        cnt_clr = 1'b1;
        tick("R2 ser_out", "R4 stage_err", "R8 err_count");
        check("R8 cleared", err_count, 16'd0);
        cnt_clr = 1'b0;
        repeat (5) tick("R2 ser_out", "R4 stage_err", "R6 err_count");

        // R1: reset in the middle of a run.
        rst = 1'b1;
        tick("R1 ser_out", "R1 stage_err", "R1 err_count");
        check("R1 mid ser_out", {15'd0, ser_out}, 16'd0);
        check("R1 mid stage_err", {12'd0, stage_err}, 16'd0);
        check("R1 mid err_count", err_count, 16'd0);
        rst = 1'b0;
        pat_sel = 2'b11;
        ser_in = 1'b1;
        repeat (12) tick("R2 ser_out", "R4 stage_err", "R5 err_count");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule